// File: doc/BRIEF.md
# SDRAM Open-Page Tracker

This block records, for each of eight SDRAM memory rows, which internal banks currently hold an open page and which page (row address) each open bank holds. A memory controller presents a row index, a bank index and a page value on the lookup port. In the same cycle it learns whether the access is a page hit, a page miss (another page is open in that bank) or a bank-empty access (no page is open). The controller reports each activate, single-bank precharge and whole-row precharge on the command port, and the table follows the DRAM state.

An 8-bit configuration input gives each row either two or four internal banks. In a two-bank row the high bank-index bit is ignored, so at most two pages can be open. In a four-bank row all four banks are tracked separately. Changing a row's configuration bit discards every open page recorded for that row. Page tags are 14 bits wide, which covers both 12-bit and 14-bit row addressing.

Top module: `sdram_page_tracker`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge), every lookup in every row and bank reports empty.
- R2: At all times outside reset, exactly one of lkHit, lkMiss and lkEmpty is high. The lookup is combinational on the current table contents.
- R3: cmdOp 2'b01 (activate) with cmdValid high records cmdPage as open in the addressed bank. From the next cycle, a lookup of that bank with the same page reports hit.
- R4: A lookup of a bank that holds an open page whose tag differs from lkPage in any of the 14 bits reports miss.
- R5: cmdOp 2'b10 (precharge) closes only the addressed bank. Lookups of that bank report empty from the next cycle, and other banks keep their pages.
- R6: cmdOp 2'b11 (precharge-all) closes every bank of the addressed row from the next cycle. Other rows are untouched.
- R7: When bankCfg[row] is 1, bank indices 0 to 3 are four independent banks, each with its own page.
- R8: When bankCfg[row] is 0, bank index bit 1 is ignored for both lookups and commands. Index 2 acts on bank 0 and index 3 acts on bank 1.
- R9: A change of bankCfg[row] invalidates all banks of that row at the next clock edge. This takes priority over any command to that row in the same cycle, and other rows keep their pages.
- R10: With cmdValid low, or with cmdOp 2'b00, the table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| bankCfg | input | 8 | Per-row bank count: 1 = four banks, 0 = two banks |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 00 none, 01 activate, 10 precharge, 11 precharge-all |
| cmdRow | input | 3 | Row addressed by the command |
| cmdBank | input | 2 | Bank addressed by the command |
| cmdPage | input | 14 | Page tag stored on activate |
| lkRow | input | 3 | Lookup row |
| lkBank | input | 2 | Lookup bank |
| lkPage | input | 14 | Lookup page |
| lkHit | output | 1 | Bank open on the requested page |
| lkMiss | output | 1 | Bank open on a different page |
| lkEmpty | output | 1 | Bank has no open page |

## Verification
A wrong valid bit or tag appears at the lookup outputs in the first cycle after the faulty edge. The condition is that the controller probes that row and bank. A lost activate shows as empty, a stale page shows as hit or miss where empty is due, and a corrupted tag turns a hit into a miss. Aliasing faults in two-bank rows appear only when the upper bank indices are probed after a write through the lower ones, or the other way round. For that reason the scenarios cross-probe index pairs 0/2 and 1/3. Configuration flushes are probed one cycle after the change, including the case where a command to the same row arrives in the same cycle.

// File: rtl/sdram_pt_pkg.sv
package sdram_pt_pkg;
  localparam int ROWS   = 8;
  localparam int BANKS  = 4;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int BANK_W = $clog2(BANKS);

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_ACT    = 2'b01,
    OP_PRE    = 2'b10,
    OP_PREALL = 2'b11
  } opE;

  typedef struct packed {
    logic              act;
    logic              pre;
    logic              preAll;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [ROWS-1:0]   flush;
  } strobeT;

  function automatic logic [BANK_W-1:0] effBank(input logic fourBank,
                                                input logic [BANK_W-1:0] idx);
    return fourBank ? idx : {{(BANK_W-1){1'b0}}, idx[0]};
  endfunction
endpackage

// File: rtl/sdram_pt_ctrl.sv
module sdram_pt_ctrl
  import sdram_pt_pkg::*;
(
  input  logic              clk,
  input  logic [ROWS-1:0]   bankCfg,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ROW_W-1:0]  cmdRow,
  input  logic [BANK_W-1:0] cmdBank,
  output strobeT            strobe
);
  logic [ROWS-1:0] cfgQ;
  opE              op;

  // Captured every cycle, including reset, so the first active cycle sees no change.
  always_ff @(posedge clk) begin
    cfgQ <= bankCfg;
  end

  always_comb begin
    op            = opE'(cmdOp);
    strobe.act    = cmdValid && (op == OP_ACT);
    strobe.pre    = cmdValid && (op == OP_PRE);
    strobe.preAll = cmdValid && (op == OP_PREALL);
    strobe.row    = cmdRow;
    strobe.bank   = effBank(bankCfg[cmdRow], cmdBank);
    strobe.flush  = bankCfg ^ cfgQ;
  end
endmodule

// File: rtl/sdram_pt_table.sv
module sdram_pt_table
  import sdram_pt_pkg::*;
#(
  parameter int TAG_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [TAG_W-1:0]  cmdPage,
  input  logic [ROWS-1:0]   bankCfg,
  input  logic [ROW_W-1:0]  lkRow,
  input  logic [BANK_W-1:0] lkBank,
  input  logic [TAG_W-1:0]  lkPage,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              lkEmpty
);
  logic             validQ [ROWS][BANKS];
  logic [TAG_W-1:0] tagQ   [ROWS][BANKS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic selRow, selBank;
      assign selRow  = (strobe.row == ROW_W'(r));
      assign selBank = (strobe.bank == BANK_W'(b));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          validQ[r][b] <= 1'b0;
        end else if (strobe.flush[r]) begin
          validQ[r][b] <= 1'b0;
        end else if (selRow) begin
          if (strobe.act && selBank) begin
            validQ[r][b] <= 1'b1;
          end else if (strobe.preAll || (strobe.pre && selBank)) begin
            validQ[r][b] <= 1'b0;
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!strobe.flush[r] && selRow && selBank && strobe.act) begin
          tagQ[r][b] <= cmdPage;
        end
      end
    end
  end

  logic [BANK_W-1:0] lkEff;
  logic              lkValid, lkMatch;

  always_comb begin
    lkEff   = effBank(bankCfg[lkRow], lkBank);
    lkValid = validQ[lkRow][lkEff];
    lkMatch = (tagQ[lkRow][lkEff] == lkPage);
    lkEmpty = !lkValid;
    lkHit   = lkValid && lkMatch;
    lkMiss  = lkValid && !lkMatch;
  end
endmodule

// File: rtl/sdram_page_tracker.sv
module sdram_page_tracker
  import sdram_pt_pkg::*;
#(
  parameter int TAG_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROWS-1:0]   bankCfg,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ROW_W-1:0]  cmdRow,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [TAG_W-1:0]  cmdPage,
  input  logic [ROW_W-1:0]  lkRow,
  input  logic [BANK_W-1:0] lkBank,
  input  logic [TAG_W-1:0]  lkPage,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              lkEmpty
);
  strobeT strobe;

  sdram_pt_ctrl u_ctrl (
    .clk      (clk),
    .bankCfg  (bankCfg),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdRow   (cmdRow),
    .cmdBank  (cmdBank),
    .strobe   (strobe)
  );

  sdram_pt_table #(.TAG_W(TAG_W)) u_table (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmdPage (cmdPage),
    .bankCfg (bankCfg),
    .lkRow   (lkRow),
    .lkBank  (lkBank),
    .lkPage  (lkPage),
    .lkHit   (lkHit),
    .lkMiss  (lkMiss),
    .lkEmpty (lkEmpty)
  );
endmodule

// File: rtl/sdram_pt_checker.sv
module sdram_pt_checker
  import sdram_pt_pkg::*;
#(
  parameter int TAG_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic [ROWS-1:0]   bankCfg,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [ROW_W-1:0]  cmdRow,
  input logic [BANK_W-1:0] cmdBank,
  input logic [TAG_W-1:0]  cmdPage,
  input logic [ROW_W-1:0]  lkRow,
  input logic [BANK_W-1:0] lkBank,
  input logic [TAG_W-1:0]  lkPage,
  input logic              lkHit,
  input logic              lkMiss,
  input logic              lkEmpty
);
  logic            inRstQ;
  logic [ROWS-1:0] cfgPrevC;
  logic [ROWS-1:0] chgQ;

  always_ff @(posedge clk) begin
    inRstQ   <= !rstN;
    cfgPrevC <= bankCfg;
    chgQ     <= rstN ? (bankCfg ^ cfgPrevC) : '0;
  end

  // R1: first cycle after reset sees an empty table
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rstN)
    inRstQ |-> lkEmpty);

  // R2: lookup result is one-hot
  assert_one_result_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({lkHit, lkMiss, lkEmpty}) == 1);

  // R3: activate then identical lookup hits
  assert_act_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b01 && bankCfg == cfgPrevC) |=>
      (lkRow != $past(cmdRow) || lkBank != $past(cmdBank) ||
       lkPage != $past(cmdPage) || bankCfg != $past(bankCfg) || lkHit));

  // R5: precharged bank reads empty
  assert_pre_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b10) |=>
      (lkRow != $past(cmdRow) || lkBank != $past(cmdBank) ||
       bankCfg != $past(bankCfg) || lkEmpty));

  // R6: precharge-all empties the row
  assert_preall_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b11) |=> (lkRow != $past(cmdRow) || lkEmpty));

  // R9: configuration change flushes the row
  assert_cfg_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    chgQ[lkRow] |-> lkEmpty);
endmodule

bind sdram_page_tracker sdram_pt_checker #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rstN(rstN), .bankCfg(bankCfg), .cmdValid(cmdValid),
  .cmdOp(cmdOp), .cmdRow(cmdRow), .cmdBank(cmdBank), .cmdPage(cmdPage),
  .lkRow(lkRow), .lkBank(lkBank), .lkPage(lkPage),
  .lkHit(lkHit), .lkMiss(lkMiss), .lkEmpty(lkEmpty)
);

// File: tb/sdram_page_tracker_tb.sv
`timescale 1ns/1ps
module sdram_page_tracker_tb;
  localparam logic [2:0] EMPTY = 3'b001;
  localparam logic [2:0] MISS  = 3'b010;
  localparam logic [2:0] HIT   = 3'b100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  bankCfg = 8'hF0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'b00;
  logic [2:0]  cmdRow = '0;
  logic [1:0]  cmdBank = '0;
  logic [13:0] cmdPage = '0;
  logic [2:0]  lkRow = '0;
  logic [1:0]  lkBank = '0;
  logic [13:0] lkPage = '0;
  logic        lkHit, lkMiss, lkEmpty;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdram_page_tracker u_dut (
    .clk(clk), .rstN(rstN), .bankCfg(bankCfg), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdRow(cmdRow), .cmdBank(cmdBank), .cmdPage(cmdPage),
    .lkRow(lkRow), .lkBank(lkBank), .lkPage(lkPage),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkEmpty(lkEmpty)
  );

  task automatic expectRes(input logic [2:0] row, input logic [1:0] bank,
                           input logic [13:0] page, input logic [2:0] exp,
                           input string req);
    logic [2:0] got;
    @(negedge clk);
    lkRow = row; lkBank = bank; lkPage = page;
    #1;
    got = {lkHit, lkMiss, lkEmpty};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s row=%0d bank=%0d page=%h got=%b expected=%b",
               req, row, bank, page, got, exp);
    end
  endtask

  task automatic doCmd(input logic valid, input logic [1:0] op, input logic [2:0] row,
                       input logic [1:0] bank, input logic [13:0] page);
    @(negedge clk);
    cmdValid = valid; cmdOp = op; cmdRow = row; cmdBank = bank; cmdPage = page;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00;
  endtask

  task automatic setCfg(input logic [7:0] v);
    @(negedge clk);
    bankCfg = v;
    @(negedge clk);
  endtask

  task automatic tReset;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int r = 0; r < 8; r++)
      for (int b = 0; b < 4; b++)
        expectRes(3'(r), 2'(b), 14'h0, EMPTY, "R1");
  endtask

  task automatic tHitMiss;
    doCmd(1'b1, 2'b01, 3'd5, 2'd2, 14'h1234);
    expectRes(3'd5, 2'd2, 14'h1234, HIT, "R3");
    expectRes(3'd5, 2'd2, 14'h1235, MISS, "R4");
    expectRes(3'd5, 2'd2, 14'h3234, MISS, "R4 high tag bit");
    expectRes(3'd5, 2'd3, 14'h1234, EMPTY, "R7 neighbour bank");
  endtask

  task automatic tFourBank;
    for (int b = 0; b < 4; b++) doCmd(1'b1, 2'b01, 3'd6, 2'(b), 14'h100 + 14'(b));
    for (int b = 0; b < 4; b++) expectRes(3'd6, 2'(b), 14'h100 + 14'(b), HIT, "R7");
  endtask

  task automatic tAlias;
    doCmd(1'b1, 2'b01, 3'd1, 2'd2, 14'h0ABC);
    expectRes(3'd1, 2'd0, 14'h0ABC, HIT, "R8 idx2->0");
    expectRes(3'd1, 2'd2, 14'h0ABC, HIT, "R8");
    doCmd(1'b1, 2'b01, 3'd1, 2'd3, 14'h0055);
    expectRes(3'd1, 2'd1, 14'h0055, HIT, "R8 idx3->1");
    expectRes(3'd1, 2'd0, 14'h0ABC, HIT, "R8 bank0 kept");
    doCmd(1'b1, 2'b01, 3'd1, 2'd0, 14'h0777);
    expectRes(3'd1, 2'd2, 14'h0ABC, MISS, "R8 overwrite");
  endtask

  task automatic tPre;
    doCmd(1'b1, 2'b10, 3'd6, 2'd1, 14'h0);
    expectRes(3'd6, 2'd1, 14'h101, EMPTY, "R5");
    expectRes(3'd6, 2'd0, 14'h100, HIT, "R5 other bank");
  endtask

  task automatic tPreAll;
    doCmd(1'b1, 2'b11, 3'd6, 2'd0, 14'h0);
    for (int b = 0; b < 4; b++) expectRes(3'd6, 2'(b), 14'h100 + 14'(b), EMPTY, "R6");
    expectRes(3'd5, 2'd2, 14'h1234, HIT, "R6 other row");
  endtask

  task automatic tIdle;
    doCmd(1'b0, 2'b01, 3'd2, 2'd0, 14'h0009);
    expectRes(3'd2, 2'd0, 14'h0009, EMPTY, "R10 no valid");
    doCmd(1'b1, 2'b00, 3'd2, 2'd0, 14'h0009);
    expectRes(3'd2, 2'd0, 14'h0009, EMPTY, "R10 op none");
    doCmd(1'b0, 2'b11, 3'd5, 2'd0, 14'h0);
    expectRes(3'd5, 2'd2, 14'h1234, HIT, "R10 idle preall");
  endtask

  task automatic tCfg;
    setCfg(8'hF2);
    expectRes(3'd1, 2'd0, 14'h0777, EMPTY, "R9");
    expectRes(3'd1, 2'd1, 14'h0055, EMPTY, "R9");
    expectRes(3'd5, 2'd2, 14'h1234, HIT, "R9 other row");
    doCmd(1'b1, 2'b01, 3'd1, 2'd3, 14'h0042);
    expectRes(3'd1, 2'd3, 14'h0042, HIT, "R7 after cfg");
    expectRes(3'd1, 2'd1, 14'h0042, EMPTY, "R7 no alias");
  endtask

  task automatic tFlushWins;
    @(negedge clk);
    bankCfg = 8'hFA;
    cmdValid = 1'b1; cmdOp = 2'b01; cmdRow = 3'd3; cmdBank = 2'd0; cmdPage = 14'h0321;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00;
    expectRes(3'd3, 2'd0, 14'h0321, EMPTY, "R9 flush priority");
    doCmd(1'b1, 2'b01, 3'd3, 2'd0, 14'h0321);
    expectRes(3'd3, 2'd0, 14'h0321, HIT, "R3 after flush");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tReset();
    tHitMiss();
    tFourBank();
    tAlias();
    tPre();
    tPreAll();
    tIdle();
    tCfg();
    tFlushWins();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule